// File: doc/BRIEF.md
# Receive Header Framer with CRC16 Check

This block sits behind a demodulator and takes one demodulated bit per strobe. While idle it slides a 16-bit window over every valid bit, hunting for the start-frame delimiter. When the window matches, the next 48 valid bits are taken as a header as they arrive. A bit-serial CRC16 runs over the first 32 header bits, and the rate code in the first byte is checked against a table of four supported rates.

A header with a matching CRC and a known rate code updates the rate-select output. In the same cycle it presents the service and length fields with a one-cycle valid pulse. The block then forwards every following valid bit to the MAC side. It never ends reception on its own: only a terminate from the MAC or a reset sends it back to delimiter search. A failed CRC or an unknown rate code silently drops the header and resumes the search.

Top module: `hdr_framer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rate_sel`, `svc_out` and `len_out` are zero, and `hdr_vld` and `pay_vld` are low. The block is searching for a delimiter with an empty window.
- R2: The delimiter is 0xF3A0, sent least significant bit first. It is found at any bit offset, including right after a partial match. The first header bit is the next valid bit after the one that completes the delimiter.
- R3: The header is 48 bits, each field sent LSB first: signal code (bits 0..7), service (8..15), length (16..31), CRC (32..47). Cycles with `bit_vld` low shift nothing.
- R4: The CRC uses x^16+x^12+x^5+1, MSB-first shifting, preset 0xFFFF, over header bits 0..31. The CRC field must equal the ones' complement of the result. On a mismatch the header is dropped: no `hdr_vld`, no payload, and the search resumes.
- R5: Signal codes 0x0A, 0x14, 0x37 and 0x6E map to `rate_sel` 0, 1, 2 and 3. Any other code drops the header like a CRC failure and leaves `rate_sel` unchanged.
- R6: On a good header, `hdr_vld` is high for exactly one cycle, starting the cycle after the edge that samples header bit 47. `rate_sel`, `svc_out` and `len_out` take their new values in that same cycle and hold them until the next good header.
- R7: After a good header, every valid input bit appears on `pay_bit` with `pay_vld` high one cycle after it is sampled. This continues with no limit from the length field.
- R8: A `mac_term` sampled high returns the block to delimiter search and drops the bit sampled with it. It clears any partial delimiter window and partial header. `pay_vld` is low in the following cycle.
- R9: `pay_vld` is never high outside payload reception (never with `hdr_vld`, never after a dropped header). `rate_sel` changes only in a cycle where `hdr_vld` is high or because of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Demodulated data bit |
| bit_vld | input | 1 | Strobe marking `bit_in` as valid |
| mac_term | input | 1 | End-of-packet terminate from the MAC |
| rate_sel | output | 2 | Selected data rate index |
| hdr_vld | output | 1 | One-cycle pulse for a good header |
| svc_out | output | 8 | Service field of the last good header |
| len_out | output | 16 | Length field of the last good header |
| pay_bit | output | 1 | Payload bit to the MAC |
| pay_vld | output | 1 | Valid strobe for `pay_bit` |

## Verification
Every result comes from a single register stage. A header's outcome is due one cycle after the edge that samples header bit 47, and each payload bit is due one cycle after its own sampling edge. The reference model in the bench advances on the same rising edge as the design, from the same input values, which are driven 1 ns after each edge. Model and design outputs are compared at the falling edge of that same cycle, so each expected value lines up with the single register stage. Scenario checks then count header pulses and payload strobes between stimuli, allowing a full idle cycle before counting.

// File: rtl/hf_pkg.sv
package hf_pkg;
    localparam int SFD_W     = 16;
    localparam logic [SFD_W-1:0] SFD_PAT = 16'hF3A0;
    localparam int HDR_BITS  = 48;
    localparam int CRC_SPAN  = 32;
    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam int NUM_RATES = 4;
    localparam int RATE_W    = $clog2(NUM_RATES);
    localparam int CODE_W    = 8;
    localparam logic [CODE_W-1:0] RATE_CODES [NUM_RATES] =
        '{8'h0A, 8'h14, 8'h37, 8'h6E};
    localparam int CNT_W     = $clog2(HDR_BITS);

    typedef enum logic [1:0] {ST_SEARCH, ST_HEADER, ST_PAYLOAD} rx_state_e;

    typedef struct packed {
        rx_state_e             st;
        logic [SFD_W-1:0]      win;
        logic [HDR_BITS-1:0]   hdr;
        logic [CNT_W-1:0]      cnt;
        logic [CRC_W-1:0]      crc;
        logic [RATE_W-1:0]     rate;
        logic [7:0]            svc;
        logic [15:0]           len;
        logic                  hv;
        logic                  pv;
        logic                  pb;
    } rx_regs_t;
endpackage

// File: rtl/hf_sfd_match.sv
module hf_sfd_match #(
    parameter int W = 16,
    parameter logic [W-1:0] PAT = '0
) (
    input  logic [W-1:0] win_q,
    input  logic         bit_in,
    output logic [W-1:0] win_d,
    output logic         hit
);
    // newest bit enters at the top: LSB-first patterns line up after W bits
    assign win_d = {bit_in, win_q[W-1:1]};
    assign hit   = (win_d == PAT);
endmodule

// File: rtl/hf_crc_step.sv
module hf_crc_step #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic [W-1:0] crc_q,
    input  logic         bit_in,
    output logic [W-1:0] crc_d
);
    logic fb;
    assign fb    = crc_q[W-1] ^ bit_in;
    assign crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/hf_rate_dec.sv
module hf_rate_dec
    import hf_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [RATE_W-1:0] idx,
    output logic              ok
);
    logic [NUM_RATES-1:0] match;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
        assign match[g] = (code == RATE_CODES[g]);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (match[i]) idx = RATE_W'(i);
        end
    end

    assign ok = |match;
endmodule

// File: rtl/hdr_framer.sv
module hdr_framer
    import hf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              mac_term,
    output logic [RATE_W-1:0] rate_sel,
    output logic              hdr_vld,
    output logic [7:0]        svc_out,
    output logic [15:0]       len_out,
    output logic              pay_bit,
    output logic              pay_vld
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_CRC  = CNT_W'(CRC_SPAN);
    localparam rx_regs_t REGS_RST = '{
        st: ST_SEARCH, win: '0, hdr: '0, cnt: '0, crc: '1,
        rate: '0, svc: '0, len: '0, hv: 1'b0, pv: 1'b0, pb: 1'b0};

    rx_regs_t q, d;

    logic [SFD_W-1:0]    win_shift;
    logic                sfd_hit;
    logic [CRC_W-1:0]    crc_step;
    logic [HDR_BITS-1:0] hdr_shift;
    logic [RATE_W-1:0]   dec_idx;
    logic                dec_ok;
    logic                crc_ok;

    hf_sfd_match #(.W(SFD_W), .PAT(SFD_PAT)) u_sfd (
        .win_q (q.win),
        .bit_in(bit_in),
        .win_d (win_shift),
        .hit   (sfd_hit)
    );

    hf_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_q (q.crc),
        .bit_in(bit_in),
        .crc_d (crc_step)
    );

    assign hdr_shift = {bit_in, q.hdr[HDR_BITS-1:1]};

    hf_rate_dec u_rate (
        .code(hdr_shift[CODE_W-1:0]),
        .idx (dec_idx),
        .ok  (dec_ok)
    );

    // CRC register is final once the 32 covered bits have passed
    assign crc_ok = (hdr_shift[HDR_BITS-1 -: CRC_W] == ~q.crc);

    always_comb begin
        d    = q;
        d.hv = 1'b0;
        d.pv = 1'b0;
        if (mac_term) begin
            d.st  = ST_SEARCH;
            d.win = '0;
            d.cnt = '0;
            d.crc = '1;
        end else if (bit_vld) begin
            unique case (q.st)
                ST_SEARCH: begin
                    d.win = win_shift;
                    if (sfd_hit) begin
                        d.st  = ST_HEADER;
                        d.win = '0;
                        d.cnt = '0;
                        d.crc = '1;
                    end
                end
                ST_HEADER: begin
                    d.hdr = hdr_shift;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt < CNT_CRC) d.crc = crc_step;
                    if (q.cnt == CNT_LAST) begin
                        d.st  = ST_SEARCH;
                        d.cnt = '0;
                        if (crc_ok && dec_ok) begin
                            d.st   = ST_PAYLOAD;
                            d.rate = dec_idx;
                            d.svc  = hdr_shift[15:8];
                            d.len  = hdr_shift[31:16];
                            d.hv   = 1'b1;
                        end
                    end
                end
                ST_PAYLOAD: begin
                    d.pv = 1'b1;
                    d.pb = bit_in;
                end
                default: d.st = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= REGS_RST;
        else     q <= d;
    end

    assign rate_sel = q.rate;
    assign hdr_vld  = q.hv;
    assign svc_out  = q.svc;
    assign len_out  = q.len;
    assign pay_bit  = q.pb;
    assign pay_vld  = q.pv;
endmodule

// File: rtl/hf_checker.sv
module hf_checker
    import hf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_in,
    input logic              bit_vld,
    input logic              mac_term,
    input logic [RATE_W-1:0] rate_sel,
    input logic              hdr_vld,
    input logic              pay_bit,
    input logic              pay_vld
);
    AST_HDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hdr_vld |=> !hdr_vld);                                        // R6
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!hdr_vld && !$past(rst)) |-> $stable(rate_sel));             // R9
    AST_PAY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        pay_vld |-> $past(bit_vld));                                  // R7
    AST_PAY_BIT_MATCH: assert property (@(posedge clk) disable iff (rst)
        pay_vld |-> (pay_bit == $past(bit_in)));                      // R7
    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (rst)
        mac_term |=> !pay_vld);                                       // R8
    AST_NO_PAY_WITH_HDR: assert property (@(posedge clk) disable iff (rst)
        hdr_vld |-> !pay_vld);                                        // R9
endmodule

bind hdr_framer hf_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .mac_term(mac_term),
    .rate_sel(rate_sel),
    .hdr_vld (hdr_vld),
    .pay_bit (pay_bit),
    .pay_vld (pay_vld)
);

// File: tb/hdr_framer_test.sv
`timescale 1ns/1ps
module hdr_framer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0, bit_vld = 1'b0, mac_term = 1'b0;
    logic [1:0]  rate_sel;
    logic        hdr_vld, pay_bit, pay_vld;
    logic [7:0]  svc_out;
    logic [15:0] len_out;

    int n_run = 0, n_fail = 0;
    int hv_seen = 0, pv_seen = 0;
    bit gap_mode = 0;
    int gap_ctr = 0;
    bit armed = 0;

    always #2 clk = ~clk;

    hdr_framer uut (.*);

    // ---------------- reference model ----------------
    int         m_state = 0;          // 0 search, 1 header, 2 payload
    int         m_win = 0;
    bit         m_hq[$];
    logic [1:0] e_rate = 0;
    logic [7:0] e_svc = 0;
    logic [15:0] e_len = 0;
    logic       e_hv = 0, e_pv = 0, e_pb = 0;

    function automatic logic [15:0] ref_crc(input logic [31:0] dat);
        logic [15:0] c;
        logic f;
        c = 16'hFFFF;
        for (int i = 0; i < 32; i++) begin
            f = c[15] ^ dat[i];
            c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    function automatic int rate_of(input logic [7:0] code);
        case (code)
            8'h0A: return 0;
            8'h14: return 1;
            8'h37: return 2;
            8'h6E: return 3;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [47:0] h;
        int r;
        armed <= 1'b1;
        if (rst) begin
            m_state = 0; m_win = 0; m_hq.delete();
            e_rate = 0; e_svc = 0; e_len = 0; e_hv = 0; e_pv = 0; e_pb = 0;
        end else begin
            e_hv = 0; e_pv = 0;
            if (mac_term) begin
                m_state = 0; m_win = 0; m_hq.delete();
            end else if (bit_vld) begin
                if (m_state == 0) begin
                    m_win = (m_win >> 1) | (int'(bit_in) << 15);
                    if (m_win == 32'h0000F3A0) begin
                        m_state = 1; m_win = 0; m_hq.delete();
                    end
                end else if (m_state == 1) begin
                    m_hq.push_back(bit_in);
                    if (m_hq.size() == 48) begin
                        for (int i = 0; i < 48; i++) h[i] = m_hq[i];
                        r = rate_of(h[7:0]);
                        m_state = 0;
                        if (r >= 0 && h[47:32] == ~ref_crc(h[31:0])) begin
                            m_state = 2;
                            e_rate = 2'(r); e_svc = h[15:8]; e_len = h[31:16];
                            e_hv = 1;
                        end
                        m_hq.delete();
                    end
                end else begin
                    e_pv = 1; e_pb = bit_in;
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            check(hdr_vld === e_hv,   "R6 hdr_vld",  int'(hdr_vld), int'(e_hv));
            check(rate_sel === e_rate,"R5 rate_sel", int'(rate_sel), int'(e_rate));
            check(svc_out === e_svc,  "R3 svc_out",  int'(svc_out), int'(e_svc));
            check(len_out === e_len,  "R3 len_out",  int'(len_out), int'(e_len));
            check(pay_vld === e_pv,   "R7 pay_vld",  int'(pay_vld), int'(e_pv));
            if (e_pv) check(pay_bit === e_pb, "R7 pay_bit", int'(pay_bit), int'(e_pb));
            if (hdr_vld) hv_seen++;
            if (pay_vld) pv_seen++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_bit(input logic b);
        bit_vld = 1'b1; bit_in = b;
        tick();
        bit_vld = 1'b0;
        gap_ctr++;
        if (gap_mode && (gap_ctr % 5 == 3)) tick();
    endtask

    task automatic send_val(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_pkt(input logic [7:0] sig, input logic [7:0] svc,
                            input logic [15:0] len, input logic [15:0] flip);
        logic [15:0] c;
        c = ~ref_crc({len, svc, sig}) ^ flip;
        send_val(16'hF3A0, 16);
        send_val({8'h0, sig}, 8);
        send_val({8'h0, svc}, 8);
        send_val(len, 16);
        send_val(c, 16);
    endtask

    task automatic send_payload(input int n);
        for (int i = 0; i < n; i++) send_bit(logic'((i * 5 + 3) % 7 > 2));
    endtask

    task automatic term();
        mac_term = 1'b1; tick(); mac_term = 1'b0;
    endtask

    initial begin
        int hv0, pv0;
        tick(); tick();
        check(rate_sel == 0 && !hdr_vld && !pay_vld && svc_out == 0 && len_out == 0,
              "R1 outputs in reset", int'(rate_sel), 0);
        rst = 1'b0; tick();
        check(!hdr_vld && !pay_vld && rate_sel == 0, "R1 after release", int'(pay_vld), 0);

        // good packet after junk, payload longer than length field
        hv0 = hv_seen;
        send_val(16'h0055, 8); send_val(16'h00F3, 8);
        send_pkt(8'h0A, 8'h5C, 16'h0003, 16'h0);
        tick();
        check(hv_seen == hv0 + 1, "R2 delimiter after junk", hv_seen - hv0, 1);
        check(svc_out == 8'h5C && len_out == 16'h0003, "R3 fields", int'(len_out), 3);
        pv0 = pv_seen;
        send_payload(40);
        tick();
        check(pv_seen - pv0 == 40, "R7 payload past length", pv_seen - pv0, 40);
        term();
        pv0 = pv_seen;
        send_payload(12); tick();
        check(pv_seen == pv0, "R8 no payload after terminate", pv_seen - pv0, 0);

        // CRC failure
        hv0 = hv_seen;
        send_pkt(8'h14, 8'h11, 16'h0040, 16'h0001);
        pv0 = pv_seen;
        send_payload(16); tick();
        check(hv_seen == hv0, "R4 bad CRC dropped", hv_seen - hv0, 0);
        check(pv_seen == pv0, "R9 no payload after bad CRC", pv_seen - pv0, 0);
        check(rate_sel == 0, "R5 rate kept on bad CRC", int'(rate_sel), 0);

        // good rate 3
        send_pkt(8'h6E, 8'hA5, 16'hBEEF, 16'h0); tick();
        check(rate_sel == 3, "R5 code 0x6E", int'(rate_sel), 3);
        send_payload(9); term();

        // unknown rate code with good CRC
        hv0 = hv_seen;
        send_pkt(8'h21, 8'h01, 16'h0100, 16'h0); send_payload(8); tick();
        check(hv_seen == hv0, "R5 unknown code dropped", hv_seen - hv0, 0);
        check(rate_sel == 3, "R5 rate unchanged", int'(rate_sel), 3);

        // terminate mid-header, then good packet with gaps
        gap_mode = 1;
        send_val(16'hF3A0, 16); send_val(16'h1234, 16); send_val(16'h0000, 4);
        term();
        hv0 = hv_seen;
        send_pkt(8'h37, 8'h3C, 16'h0777, 16'h0); tick();
        check(hv_seen == hv0 + 1, "R8 header restarts after terminate", hv_seen - hv0, 1);
        check(rate_sel == 2, "R3 rate with idle gaps", int'(rate_sel), 2);
        send_payload(20); term();

        // terminate clears a partial delimiter
        send_val(16'hF3A0, 10); term();
        hv0 = hv_seen;
        send_val(16'hF3A0 >> 10, 6);
        send_val(16'h0, 10); tick();
        check(hv_seen == hv0 && !pay_vld, "R8 partial delimiter cleared", hv_seen - hv0, 0);
        gap_mode = 0;

        // overlapping partial match before the delimiter
        hv0 = hv_seen;
        send_val(16'h00A0, 8); send_val(16'h03A0, 10);
        send_pkt(8'h14, 8'h77, 16'h2222, 16'h0); tick();
        check(hv_seen == hv0 + 1 && rate_sel == 1, "R2 overlap search", int'(rate_sel), 1);

        // reset during payload
        send_payload(6);
        rst = 1'b1; tick(); tick();
        check(rate_sel == 0 && svc_out == 0 && !pay_vld, "R1 reset in payload", int'(rate_sel), 0);
        rst = 1'b0; tick();
        pv0 = pv_seen;
        send_payload(10); tick();
        check(pv_seen == pv0, "R1 search after reset", pv_seen - pv0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule